// File: doc/BRIEF.md
# Single-Wire Identity Responder

This block is the slave side of an open-drain single-wire bus. It holds a 64-bit identity word, given as a parameter, and watches the sampled bus line. A long low on the line is a bus reset. The block answers each reset with a presence pulse. It then takes in an 8-bit command. Two opcodes make it send its identity. One opcode makes it join the bitwise search arbitration. All other codes leave it silent until the next reset. The only connection to the line is a pull-low enable, which drives the external open-drain pad.

Every bus time is a count of system clocks. The counts come from the `CLK_HZ` parameter and the microsecond parameters. The line input goes through a two-flop synchronizer, and edges are detected on the synchronized value.

The FSM has eight states:
- `ST_IDLE`: wait for a reset.
- `ST_PD_WAIT`: delay after the reset ends.
- `ST_PD_LOW`: presence pulse.
- `ST_CMD`: command receive.
- `ST_READ`: identity transmit.
- `ST_SRCH_BIT`, `ST_SRCH_CMP`, `ST_SRCH_WR`: the three slots of each search step.

Transitions:
- Reset detected (any state) → `ST_PD_WAIT`.
- `ST_PD_WAIT` → `ST_PD_LOW` when the wait expires.
- `ST_PD_LOW` → `ST_CMD`.
- `ST_CMD` → `ST_READ` on a read opcode, `ST_SRCH_BIT` on the search opcode, `ST_IDLE` on anything else.
- `ST_READ` → `ST_IDLE` after bit 63.
- `ST_SRCH_BIT` → `ST_SRCH_CMP` → `ST_SRCH_WR` → `ST_SRCH_BIT` while the bits still match.
- `ST_SRCH_WR` → `ST_IDLE` on a mismatch or after bit 63.
- Over-long low in a transaction state → `ST_IDLE`.

Top module: `wire_id_responder`

## Requirements
- R1: A line low of at least `RST_LOW_US` that then rises is a reset and is answered by a presence pulse. A low of 400 µs followed by a rise gives no presence pulse.
- R2: After a reset ends, `pull_low` rises between 15 µs and 60 µs later. It then stays asserted for between 60 µs and 240 µs.
- R3: After presence, eight slots are taken as one command byte, least significant bit first. The code appears on `cmd_code` together with a one-cycle `cmd_stb` after the eighth slot.
- R4: After command 33h or 0Fh, the next 64 read slots return `ID_CODE` bit 0 first. A 0 holds the line low from shortly after the falling edge until past the 15 µs mark. A 1 leaves the line released. `id_sent` pulses once after bit 63.
- R5: After command 55h or CCh, the block drives nothing until the next reset.
- R6: After any other command code (for example A5h), the block drives nothing until the next reset.
- R7: After command F0h, each of the 64 bits takes three slots: the bit, its complement, then a sampled master write. When every write matches, `id_sent` pulses after bit 63.
- R8: If a written search bit differs from the block's own bit, `search_lost` pulses once. The block then drives nothing until the next reset.
- R9: A low longer than 120 µs during a command, read or search aborts the transaction. If that low is shorter than `RST_LOW_US`, no presence pulse follows.
- R10: While `rst_n` is low and just after it, `pull_low` is 0 and no status pulse appears.
- R11: A full reset low that starts with a read slot, while the block is pulling low for a 0 bit, aborts the read and is answered by a presence pulse. A following 0Fh command then returns the whole identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Raw bus line level |
| pull_low | output | 1 | 1 = pull the bus line low |
| cmd_code | output | 8 | Last command byte received |
| cmd_stb | output | 1 | One-cycle pulse when a command byte completes |
| id_sent | output | 1 | One-cycle pulse when a read or a search completes all 64 bits |
| search_lost | output | 1 | One-cycle pulse when the block drops out of a search |

## Verification
The coincidence tested is a reset low that arrives while a 0-bit read hold is active. In that case the slot-hold timer and the low-duration meter run on the same low. The abort, and then the reset rise, must override the hold.

The bench provokes it by reading nine identity bits and then starting a 500 µs low on the slot where bit 9 (a 0) is being driven. It judges the result at the ports. A presence pulse must appear in the legal window, and a later 0Fh read must return the complete identity, which shows that no stale bit index or pull survived the abort.

// File: rtl/wire_id_pkg.sv
package wire_id_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PD_WAIT,
        ST_PD_LOW,
        ST_CMD,
        ST_READ,
        ST_SRCH_BIT,
        ST_SRCH_CMP,
        ST_SRCH_WR
    } wid_state_e;

    localparam logic [7:0] OP_READ_A = 8'h33;
    localparam logic [7:0] OP_READ_B = 8'h0F;
    localparam logic [7:0] OP_SEARCH = 8'hF0;

    localparam int ID_BITS = 64;

    // Converts a duration in microseconds to system clock cycles.
    function automatic int us_to_cyc(input int clk_hz, input int us);
        return (clk_hz / 1_000_000) * us;
    endfunction

endpackage

// File: rtl/wire_id_sync.sv
module wire_id_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] shreg;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '1;
            prev  <= 1'b1;
        end else begin
            shreg <= {shreg[STAGES-2:0], line_in};
            prev  <= shreg[STAGES-1];
        end
    end

    assign line_s = shreg[STAGES-1];
    assign fall   = prev & ~line_s;
    assign rise   = ~prev & line_s;
endmodule

// File: rtl/wire_id_lowmeter.sv
module wire_id_lowmeter #(
    parameter int RST_CYC   = 480,
    parameter int ABORT_CYC = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    input  logic rise,
    output logic long_low,
    output logic reset_rise
);
    localparam int LW = $clog2(RST_CYC + 1);
    localparam logic [LW-1:0] RST_V   = LW'(RST_CYC);
    localparam logic [LW-1:0] ABORT_V = LW'(ABORT_CYC);

    logic [LW-1:0] low_cnt;

    // Counts low cycles and saturates at the reset threshold.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              low_cnt <= '0;
        else if (line_s)         low_cnt <= '0;
        else if (low_cnt != RST_V) low_cnt <= low_cnt + 1'b1;
    end

    assign long_low   = !line_s && (low_cnt > ABORT_V);
    assign reset_rise = rise && (low_cnt >= RST_V);
endmodule

// File: rtl/wire_id_timer.sv
module wire_id_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] len,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (start)     cnt <= len;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign done = (cnt == {{(TW-1){1'b0}}, 1'b1});
endmodule

// File: rtl/wire_id_responder.sv
module wire_id_responder
    import wire_id_pkg::*;
#(
    parameter logic [63:0] ID_CODE    = 64'h5C00_A1B2_C3D4_E501,
    parameter int          CLK_HZ     = 1_000_000,
    parameter int          RST_LOW_US = 480,
    parameter int          PD_WAIT_US = 30,
    parameter int          PD_LOW_US  = 100,
    parameter int          SAMPLE_US  = 30,
    parameter int          HOLD0_US   = 30,
    parameter int          ABORT_US   = 120
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    output logic       pull_low,
    output logic [7:0] cmd_code,
    output logic       cmd_stb,
    output logic       id_sent,
    output logic       search_lost
);
    localparam int RST_CYC   = us_to_cyc(CLK_HZ, RST_LOW_US);
    localparam int PDW_CYC   = us_to_cyc(CLK_HZ, PD_WAIT_US);
    localparam int PDL_CYC   = us_to_cyc(CLK_HZ, PD_LOW_US);
    localparam int SMP_CYC   = us_to_cyc(CLK_HZ, SAMPLE_US);
    localparam int HLD_CYC   = us_to_cyc(CLK_HZ, HOLD0_US);
    localparam int ABORT_CYC = us_to_cyc(CLK_HZ, ABORT_US);
    localparam int TW        = $clog2(PDW_CYC + PDL_CYC + SMP_CYC + HLD_CYC + 1);
    localparam int IW        = $clog2(ID_BITS);
    localparam logic [TW-1:0] PDW_T = TW'(PDW_CYC);
    localparam logic [TW-1:0] PDL_T = TW'(PDL_CYC);
    localparam logic [TW-1:0] SMP_T = TW'(SMP_CYC);
    localparam logic [TW-1:0] HLD_T = TW'(HLD_CYC);
    localparam logic [IW-1:0] LAST_BIT = IW'(ID_BITS - 1);

    logic line_s, fall, rise;
    logic long_low, rst_rise;
    logic t_start, t_done;
    logic [TW-1:0] t_len;

    wid_state_e    state, state_nx;
    logic [IW-1:0] bit_idx, idx_nx;
    logic [7:0]    cmd_sr, cmd_sr_nx;
    logic          in_slot, in_slot_nx;
    logic          slot_pull, slot_pull_nx;
    logic [7:0]    code_nx;
    logic          stb_nx, sent_nx, lost_nx;
    logic          cur_bit;
    logic [7:0]    byte_in;
    logic          xact;

    wire_id_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .line_s(line_s), .fall(fall), .rise(rise)
    );

    wire_id_lowmeter #(.RST_CYC(RST_CYC), .ABORT_CYC(ABORT_CYC)) u_low (
        .clk(clk), .rst_n(rst_n), .line_s(line_s), .rise(rise),
        .long_low(long_low), .reset_rise(rst_rise)
    );

    wire_id_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(t_start), .len(t_len), .done(t_done)
    );

    assign cur_bit = ID_CODE[bit_idx];
    assign byte_in = {line_s, cmd_sr[7:1]};
    assign xact    = (state == ST_CMD) || (state == ST_READ) || (state == ST_SRCH_BIT)
                  || (state == ST_SRCH_CMP) || (state == ST_SRCH_WR);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bit_idx     <= '0;
            cmd_sr      <= '0;
            in_slot     <= 1'b0;
            slot_pull   <= 1'b0;
            cmd_code    <= '0;
            cmd_stb     <= 1'b0;
            id_sent     <= 1'b0;
            search_lost <= 1'b0;
        end else begin
            state       <= state_nx;
            bit_idx     <= idx_nx;
            cmd_sr      <= cmd_sr_nx;
            in_slot     <= in_slot_nx;
            slot_pull   <= slot_pull_nx;
            cmd_code    <= code_nx;
            cmd_stb     <= stb_nx;
            id_sent     <= sent_nx;
            search_lost <= lost_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx     = state;
        idx_nx       = bit_idx;
        cmd_sr_nx    = cmd_sr;
        in_slot_nx   = in_slot;
        slot_pull_nx = slot_pull;
        code_nx      = cmd_code;
        stb_nx       = 1'b0;
        sent_nx      = 1'b0;
        lost_nx      = 1'b0;
        t_start      = 1'b0;
        t_len        = '0;

        if (rst_rise) begin
            state_nx     = ST_PD_WAIT;
            in_slot_nx   = 1'b0;
            slot_pull_nx = 1'b0;
            t_start      = 1'b1;
            t_len        = PDW_T;
        end else if (long_low && xact) begin
            state_nx     = ST_IDLE;
            in_slot_nx   = 1'b0;
            slot_pull_nx = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_PD_WAIT: begin
                    if (t_done) begin
                        state_nx = ST_PD_LOW;
                        t_start  = 1'b1;
                        t_len    = PDL_T;
                    end
                end
                ST_PD_LOW: begin
                    if (t_done) begin
                        state_nx = ST_CMD;
                        idx_nx   = '0;
                    end
                end
                ST_CMD: begin
                    if (fall && !in_slot) begin
                        in_slot_nx = 1'b1;
                        t_start    = 1'b1;
                        t_len      = SMP_T;
                    end else if (t_done && in_slot) begin
                        in_slot_nx = 1'b0;
                        cmd_sr_nx  = byte_in;
                        if (bit_idx == IW'(7)) begin
                            idx_nx  = '0;
                            stb_nx  = 1'b1;
                            code_nx = byte_in;
                            if (byte_in == OP_READ_A || byte_in == OP_READ_B)
                                state_nx = ST_READ;
                            else if (byte_in == OP_SEARCH)
                                state_nx = ST_SRCH_BIT;
                            else
                                state_nx = ST_IDLE;
                        end else begin
                            idx_nx = bit_idx + 1'b1;
                        end
                    end
                end
                ST_READ, ST_SRCH_BIT, ST_SRCH_CMP: begin
                    if (fall && !in_slot) begin
                        in_slot_nx   = 1'b1;
                        slot_pull_nx = (state == ST_SRCH_CMP) ? cur_bit : !cur_bit;
                        t_start      = 1'b1;
                        t_len        = HLD_T;
                    end else if (t_done && in_slot) begin
                        in_slot_nx   = 1'b0;
                        slot_pull_nx = 1'b0;
                        if (state == ST_SRCH_BIT)      state_nx = ST_SRCH_CMP;
                        else if (state == ST_SRCH_CMP) state_nx = ST_SRCH_WR;
                        else if (bit_idx == LAST_BIT) begin
                            state_nx = ST_IDLE;
                            sent_nx  = 1'b1;
                        end else begin
                            idx_nx = bit_idx + 1'b1;
                        end
                    end
                end
                ST_SRCH_WR: begin
                    if (fall && !in_slot) begin
                        in_slot_nx = 1'b1;
                        t_start    = 1'b1;
                        t_len      = SMP_T;
                    end else if (t_done && in_slot) begin
                        in_slot_nx = 1'b0;
                        if (line_s != cur_bit) begin
                            state_nx = ST_IDLE;
                            lost_nx  = 1'b1;
                        end else if (bit_idx == LAST_BIT) begin
                            state_nx = ST_IDLE;
                            sent_nx  = 1'b1;
                        end else begin
                            idx_nx   = bit_idx + 1'b1;
                            state_nx = ST_SRCH_BIT;
                        end
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        pull_low = (state == ST_PD_LOW) || (in_slot && slot_pull);
    end
endmodule

// File: rtl/wire_id_checker.sv
module wire_id_checker #(
    parameter int CLK_HZ = 1_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pull_low,
    input logic [7:0] cmd_code,
    input logic       cmd_stb,
    input logic       id_sent,
    input logic       search_lost,
    input logic       rst_rise
);
    localparam int MAX_PULL = 240 * (CLK_HZ / 1_000_000);

    int   pull_run;
    logic quiet;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull_run <= 0;
            quiet    <= 1'b0;
        end else begin
            pull_run <= pull_low ? pull_run + 1 : 0;
            if (rst_rise)
                quiet <= 1'b0;
            else if (search_lost ||
                     (cmd_stb && cmd_code != 8'h33 && cmd_code != 8'h0F && cmd_code != 8'hF0))
                quiet <= 1'b1;
        end
    end

    // R1: the cycle after a reset is recognised starts the wait, so the line is released
    a_r1_wait_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rst_rise |=> !pull_low);

    // R2: no pull lasts longer than the longest allowed presence pulse
    a_r2_pull_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pull_low |-> (pull_run < MAX_PULL));

    // R5, R6 and R8: silent after an ignored code or a lost search
    a_r5_quiet_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> !pull_low);

    // R8: a dropped search never also reports completion
    a_r8_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_stb, id_sent, search_lost}));

    // R10: released while held in reset
    always @(posedge clk) begin
        if (!rst_n) a_r10_reset_quiet: assert (!pull_low && !cmd_stb);
    end
endmodule

bind wire_id_responder wire_id_checker #(.CLK_HZ(CLK_HZ)) u_chk (
    .clk(clk), .rst_n(rst_n), .pull_low(pull_low), .cmd_code(cmd_code),
    .cmd_stb(cmd_stb), .id_sent(id_sent), .search_lost(search_lost),
    .rst_rise(rst_rise)
);

// File: tb/wire_id_responder_bench.sv
module wire_id_responder_bench;
    // Time is scaled: the design is told one clock is one microsecond.
    localparam logic [63:0] ID = 64'h5C00_A1B2_C3D4_E501;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_low = 1'b0;
    logic pull_low, cmd_stb, id_sent, search_lost;
    logic [7:0] cmd_code;
    wire  bus = ~(m_low | pull_low);

    int checks = 0, errors = 0;
    int stb_cnt = 0, sent_cnt = 0, lost_cnt = 0;
    logic [7:0] last_code = 8'h00;

    always #5 clk = ~clk;

    wire_id_responder #(.ID_CODE(ID), .CLK_HZ(1_000_000)) u_wire_id_responder (
        .clk(clk), .rst_n(rst_n), .line_in(bus), .pull_low(pull_low),
        .cmd_code(cmd_code), .cmd_stb(cmd_stb), .id_sent(id_sent),
        .search_lost(search_lost)
    );

    always @(posedge clk) begin
        if (cmd_stb) begin stb_cnt++; last_code = cmd_code; end
        if (id_sent) sent_cnt++;
        if (search_lost) lost_cnt++;
    end

    // kind: 0 silent, 1 identity read, 2 search
    localparam logic [9:0] VEC [6] = '{
        {8'h33, 2'd1}, {8'h0F, 2'd1}, {8'hF0, 2'd2},
        {8'h55, 2'd0}, {8'hCC, 2'd0}, {8'hA5, 2'd0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input int low_len, output bit seen,
                            output int wait_c, output int len_c);
        seen = 0; wait_c = 0; len_c = 0;
        m_low = 1'b1; idle(low_len); m_low = 1'b0;
        for (int i = 0; i < 480; i++) begin
            @(negedge clk);
            if (pull_low) begin
                if (!seen) wait_c = i;
                seen = 1;
                len_c++;
            end
        end
    endtask

    task automatic write_bit(input bit b);
        if (b) begin m_low = 1'b1; idle(5);  m_low = 1'b0; idle(65); end
        else   begin m_low = 1'b1; idle(65); m_low = 1'b0; idle(5);  end
    endtask

    task automatic read_bit(output bit b);
        m_low = 1'b1; idle(5); m_low = 1'b0; idle(8);
        b = bus;
        idle(57);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) write_bit(v[i]);
    endtask

    task automatic read_bits(input int n, output logic [63:0] v);
        bit b;
        v = '0;
        for (int i = 0; i < n; i++) begin read_bit(b); v[i] = b; end
    endtask

    task automatic search_steps(input int n, output logic [63:0] bits,
                                output logic [63:0] cmps);
        bit b, c;
        bits = '0; cmps = '0;
        for (int i = 0; i < n; i++) begin
            read_bit(b); read_bit(c);
            bits[i] = b; cmps[i] = c;
            write_bit(ID[i]);
        end
    endtask

    function automatic string tag_of(input logic [7:0] op, input logic [1:0] kind);
        if (kind == 2'd1) return "R4";
        if (kind == 2'd2) return "R7";
        if (op == 8'h55 || op == 8'hCC) return "R5";
        return "R6";
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit seen;
        int wc, lc, s0, t0;
        logic [63:0] v, c;

        // R10: reset state
        idle(4);
        check(!pull_low && !cmd_stb, "R10", "outputs in reset", {62'd0, pull_low, cmd_stb}, 0);
        rst_n = 1'b1;
        idle(20);
        check(!pull_low && stb_cnt == 0 && sent_cnt == 0 && lost_cnt == 0, "R10",
              "quiet after reset", {63'd0, pull_low}, 0);

        // R1: short low is no reset
        do_reset(400, seen, wc, lc);
        check(!seen, "R1", "presence after 400us low", {63'd0, seen}, 0);

        // Vector table
        for (int k = 0; k < 6; k++) begin
            logic [7:0] op;
            logic [1:0] kind;
            string t;
            op = VEC[k][9:2]; kind = VEC[k][1:0]; t = tag_of(op, kind);
            do_reset(500, seen, wc, lc);
            check(seen, "R1", "presence after reset", {63'd0, seen}, 1);
            check(wc >= 15 && wc <= 60 && lc >= 60 && lc <= 240, "R2", "presence timing",
                  {32'(wc), 32'(lc)}, {32'd30, 32'd100});
            s0 = stb_cnt; t0 = sent_cnt;
            send_byte(op);
            idle(2);
            check(stb_cnt == s0 + 1 && last_code == op, "R3", "command byte",
                  {56'd0, last_code}, {56'd0, op});
            if (kind == 2'd1) begin
                read_bits(64, v);
                idle(2);
                check(v == ID, t, "identity read", v, ID);
                check(sent_cnt == t0 + 1, t, "id_sent after read", 64'(sent_cnt - t0), 1);
            end else if (kind == 2'd2) begin
                search_steps(64, v, c);
                idle(2);
                check(v == ID, "R7", "search bits", v, ID);
                check(c == ~ID, "R7", "search complements", c, ~ID);
                check(sent_cnt == t0 + 1, "R7", "id_sent after search", 64'(sent_cnt - t0), 1);
            end else begin
                read_bits(16, v);
                check(v[15:0] == 16'hFFFF, t, "line stays released", v, 64'hFFFF);
            end
        end

        // R8: search mismatch at bit 5
        do_reset(500, seen, wc, lc);
        send_byte(8'hF0);
        search_steps(5, v, c);
        s0 = lost_cnt; t0 = sent_cnt;
        read_bits(2, v);
        write_bit(!ID[5]);
        idle(2);
        check(lost_cnt == s0 + 1 && sent_cnt == t0, "R8", "search_lost pulse",
              64'(lost_cnt - s0), 1);
        read_bits(8, v);
        check(v[7:0] == 8'hFF, "R8", "silent after drop-out", v, 64'hFF);

        // R9: 200us low mid-read aborts, no presence
        do_reset(500, seen, wc, lc);
        send_byte(8'h33);
        read_bits(3, v);
        do_reset(200, seen, wc, lc);
        check(!seen, "R9", "no presence after 200us low", {63'd0, seen}, 0);
        read_bits(8, v);
        check(v[7:0] == 8'hFF, "R9", "read aborted", v, 64'hFF);

        // R11: reset low begins on a slot where bit 9 (0) is being held
        do_reset(500, seen, wc, lc);
        send_byte(8'h33);
        read_bits(9, v);
        check(v[8:0] == ID[8:0], "R11", "first nine bits", v, {55'd0, ID[8:0]});
        do_reset(500, seen, wc, lc);
        check(seen && wc >= 15 && wc <= 60, "R11", "presence after mid-read reset",
              {32'(seen), 32'(wc)}, {32'd1, 32'd30});
        send_byte(8'h0F);
        read_bits(64, v);
        check(v == ID, "R11", "full read after reset", v, ID);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule